// File: doc/BRIEF.md
# Addressable LED Frame Sequencer

This block produces the timing skeleton for one frame sent to a chain of serially addressed RGB LEDs. After reset it holds a latch phase. It then walks through every LED in index order and, inside each LED, through all 24 bits of its colour word. Within each bit it counts clock cycles. Each cycle it publishes a tagged control word. The word says either "latch phase" or gives the LED index, the bit index and the cycle count inside that bit.

A separate waveform stage reads this word and decides the level of the serial line. Pixel storage and the line driver sit outside this block. The latch length and the bit period arrive at run time as cycle counts on input ports, so one netlist can serve several clock frequencies. The other sub-bit thresholds (high and low times for 0 and 1 bits) belong to the waveform stage, so they are not inputs here. The number of LEDs is a parameter.

Top module: `ledseq_frame`

## Requirements
- R1: While `rst_i` is high (synchronous, active high), `ctrl_o` is all zeros. In the first cycle after `rst_i` falls, `ctrl_o` is still the latch word (all zeros).
- R2: The latch phase lasts `latch_cycles_i + 1` cycles: its internal counter runs from 0 up to `latch_cycles_i`. The next cycle shows LED 0, bit 0, count 0.
- R3: `ctrl_o` is packed from the MSB down as follows: a 1-bit tag (1 = LED data, 0 = latch), then the LED index (`LED_W` bits, 4 by default), then the bit index (5 bits with 24 bits per LED), then the cycle count (`TIME_W` bits, in the LSBs). In the latch phase every field reads zero.
- R4: Inside a bit the count starts at 0 and rises by one each cycle up to `bit_cycles_i`. Each bit therefore lasts `bit_cycles_i + 1` cycles, and the LED and bit indices stay constant during that time.
- R5: In the cycle after the count has reached `bit_cycles_i`, the bit index rises by one and the count returns to 0. Bits run 0, 1, …, 23.
- R6: After bit 23, the next cycle shows bit 0 of the next LED. LEDs run 0 to `NUM_LEDS-1`, and the indices never leave these ranges.
- R7: After the last cycle of bit 23 of LED `NUM_LEDS-1`, the block returns to the latch phase with its counter at 0. The following frame repeats the same sequence.
- R8: Both timing inputs are read in every cycle. If `bit_cycles_i` is lowered to or below the current count in the middle of a bit, that bit ends at the next clock edge, and later bits use the new period.
- R9: A `latch_cycles_i` of 0 gives a single latch cycle. A `bit_cycles_i` of 0 gives one cycle per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| latch_cycles_i | input | TIME_W | Last count value of the latch phase |
| bit_cycles_i | input | TIME_W | Last count value inside one bit |
| ctrl_o | output | 1+LED_W+BIT_W+TIME_W | Tagged control word |

## Verification
The bench uses the default build: ten LEDs, 24 bits per LED and 16-bit cycle counts. Ten is not a power of two, so both index counters use their compare-and-wrap form. Run-time timing values as small as 0 and up to 7 keep each frame short. This allows several complete frames, including the return from the last LED to the latch phase, to be checked cycle by cycle. It also allows a mid-bit cut of the bit period and the single-cycle latch and bit cases to be checked.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

   // Which half of the frame the sequencer is in
   typedef enum logic {
      PH_LATCH = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;

endpackage

// File: rtl/ledseq_dur_ctr.sv
// Cycle counter that restarts once it reaches a run-time limit.
module ledseq_dur_ctr #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] cnt_o,
   output logic         done_o
);

   logic [W-1:0] cnt_q;

   // ">=" so a limit lowered below the count ends the span at once
   assign done_o = (cnt_q >= limit_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (done_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ledseq_idx_ctr.sv
// Index counter 0..COUNT-1 that advances on step_i and wraps.
module ledseq_idx_ctr #(
   parameter  int COUNT = 24,
   localparam int W     = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         step_i,
   output logic [W-1:0] idx_o,
   output logic         last_o
);

   initial begin
      assert (COUNT >= 1) else $error("ledseq_idx_ctr: COUNT must be at least 1");
   end

   generate
      if (COUNT == 1) begin : g_single
         assign idx_o  = '0;
         assign last_o = 1'b1;
      end else if ((2 ** W) == COUNT) begin : g_pow2
         // Natural wrap of the register, so no compare is needed
         logic [W-1:0] idx_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               idx_q <= '0;
            end else if (step_i) begin
               idx_q <= idx_q + 1'b1;
            end
         end
         assign idx_o  = idx_q;
         assign last_o = &idx_q;
      end else begin : g_cmp
         logic [W-1:0] idx_q;
         logic         at_end;
         assign at_end = (idx_q == W'(COUNT - 1));
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               idx_q <= '0;
            end else if (step_i) begin
               idx_q <= at_end ? '0 : idx_q + 1'b1;
            end
         end
         assign idx_o  = idx_q;
         assign last_o = at_end;
      end
   endgenerate

endmodule

// File: rtl/ledseq_encode.sv
// Packs the counter state into the tagged control word.
module ledseq_encode
   import ledseq_pkg::*;
#(
   parameter  int LED_W  = 4,
   parameter  int BIT_W  = 5,
   parameter  int TIME_W = 16,
   localparam int CTRL_W = 1 + LED_W + BIT_W + TIME_W
) (
   input  phase_e              phase_i,
   input  logic [LED_W-1:0]    led_i,
   input  logic [BIT_W-1:0]    bit_i,
   input  logic [TIME_W-1:0]   dur_i,
   output logic [CTRL_W-1:0]   ctrl_o
);

   always_comb begin
      if (phase_i == PH_DATA) begin
         ctrl_o = {1'b1, led_i, bit_i, dur_i};
      end else begin
         ctrl_o = '0;
      end
   end

endmodule

// File: rtl/ledseq_frame.sv
// Frame sequencer top: latch phase, then LEDs x bits x cycle count.
module ledseq_frame
   import ledseq_pkg::*;
#(
   parameter  int NUM_LEDS     = 10,
   parameter  int BITS_PER_LED = 24,
   parameter  int TIME_W       = 16,
   localparam int LED_W        = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
   localparam int BIT_W        = (BITS_PER_LED > 1) ? $clog2(BITS_PER_LED) : 1,
   localparam int CTRL_W       = 1 + LED_W + BIT_W + TIME_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [TIME_W-1:0] latch_cycles_i,
   input  logic [TIME_W-1:0] bit_cycles_i,
   output logic [CTRL_W-1:0] ctrl_o
);

   initial begin
      assert (NUM_LEDS >= 1)     else $error("ledseq_frame: NUM_LEDS must be at least 1");
      assert (BITS_PER_LED >= 1) else $error("ledseq_frame: BITS_PER_LED must be at least 1");
      assert (TIME_W >= 1)       else $error("ledseq_frame: TIME_W must be at least 1");
   end

   phase_e             phase_q;
   logic [TIME_W-1:0]  span_limit;
   logic [TIME_W-1:0]  dur_cnt;
   logic               span_done;
   logic [BIT_W-1:0]   bit_idx;
   logic [LED_W-1:0]   led_idx;
   logic               bit_last;
   logic               led_last;
   logic               bit_step;
   logic               led_step;
   logic               frame_end;

   // One counter serves both phases; only its limit changes
   assign span_limit = (phase_q == PH_DATA) ? bit_cycles_i : latch_cycles_i;
   assign bit_step   = (phase_q == PH_DATA) && span_done;
   assign led_step   = bit_step && bit_last;
   assign frame_end  = led_step && led_last;

   ledseq_dur_ctr #(
      .W (TIME_W)
   ) i_dur (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .limit_i (span_limit),
      .cnt_o   (dur_cnt),
      .done_o  (span_done)
   );

   ledseq_idx_ctr #(
      .COUNT (BITS_PER_LED)
   ) i_bit (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (bit_step),
      .idx_o  (bit_idx),
      .last_o (bit_last)
   );

   ledseq_idx_ctr #(
      .COUNT (NUM_LEDS)
   ) i_led (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (led_step),
      .idx_o  (led_idx),
      .last_o (led_last)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_LATCH;
      end else if ((phase_q == PH_LATCH) && span_done) begin
         phase_q <= PH_DATA;
      end else if (frame_end) begin
         phase_q <= PH_LATCH;
      end
   end

   ledseq_encode #(
      .LED_W  (LED_W),
      .BIT_W  (BIT_W),
      .TIME_W (TIME_W)
   ) i_enc (
      .phase_i (phase_q),
      .led_i   (led_idx),
      .bit_i   (bit_idx),
      .dur_i   (dur_cnt),
      .ctrl_o  (ctrl_o)
   );

endmodule

// File: rtl/ledseq_frame_chk.sv
// Temporal checks for ledseq_frame, attached with bind below.
module ledseq_frame_chk #(
   parameter  int NUM_LEDS     = 10,
   parameter  int BITS_PER_LED = 24,
   parameter  int TIME_W       = 16,
   localparam int LED_W        = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
   localparam int BIT_W        = (BITS_PER_LED > 1) ? $clog2(BITS_PER_LED) : 1,
   localparam int CTRL_W       = 1 + LED_W + BIT_W + TIME_W
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [TIME_W-1:0] latch_cycles_i,
   input logic [TIME_W-1:0] bit_cycles_i,
   input logic [CTRL_W-1:0] ctrl_o,
   input logic [TIME_W-1:0] dur_cnt
);

   logic              tag;
   logic [LED_W-1:0]  lidx;
   logic [BIT_W-1:0]  bidx;
   logic [TIME_W-1:0] dur;

   assign tag  = ctrl_o[CTRL_W-1];
   assign lidx = ctrl_o[CTRL_W-2 -: LED_W];
   assign bidx = ctrl_o[TIME_W+BIT_W-1 -: BIT_W];
   assign dur  = ctrl_o[TIME_W-1:0];

   // R1: first cycle out of reset shows the latch word
   p_release_latch_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(rst_i) |-> (ctrl_o == '0));

   // R2: latch counter climbs while below its limit
   p_latch_stay_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!tag && (dur_cnt < latch_cycles_i)) |=> (!tag && (dur_cnt == $past(dur_cnt) + 1'b1)));

   // R2: latch ends into LED 0, bit 0, count 0
   p_latch_exit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!tag && (dur_cnt >= latch_cycles_i)) |=> (tag && (lidx == '0) && (bidx == '0) && (dur == '0)));

   // R4: count steps by one inside a bit, indices hold
   p_dur_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (tag && (dur < bit_cycles_i)) |=>
         (tag && (dur == $past(dur) + 1'b1) && $stable(lidx) && $stable(bidx)));

   // R5: end of a bit moves to the next bit of the same LED
   p_bit_next_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (tag && (dur >= bit_cycles_i) && (bidx != BIT_W'(BITS_PER_LED - 1))) |=>
         (tag && (bidx == $past(bidx) + 1'b1) && (dur == '0) && $stable(lidx)));

   // R6: end of bit 23 moves to bit 0 of the next LED
   p_led_next_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (tag && (dur >= bit_cycles_i) && (bidx == BIT_W'(BITS_PER_LED - 1))
           && (lidx != LED_W'(NUM_LEDS - 1))) |=>
         (tag && (bidx == '0) && (lidx == $past(lidx) + 1'b1) && (dur == '0)));

   // R6: indices stay in range
   p_idx_range_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      tag |-> ((lidx < LED_W'(NUM_LEDS)) && (32'(bidx) < BITS_PER_LED)));

   // R7: end of the last bit of the last LED returns to the latch phase
   p_frame_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (tag && (dur >= bit_cycles_i) && (bidx == BIT_W'(BITS_PER_LED - 1))
           && (lidx == LED_W'(NUM_LEDS - 1))) |=> ((ctrl_o == '0) && (dur_cnt == '0)));

endmodule

bind ledseq_frame ledseq_frame_chk #(
   .NUM_LEDS     (NUM_LEDS),
   .BITS_PER_LED (BITS_PER_LED),
   .TIME_W       (TIME_W)
) i_ledseq_frame_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .latch_cycles_i (latch_cycles_i),
   .bit_cycles_i   (bit_cycles_i),
   .ctrl_o         (ctrl_o),
   .dur_cnt        (dur_cnt)
);

// File: tb/test_ledseq_frame.sv
`timescale 1ns/1ps
module test_ledseq_frame;

   localparam int NL = 10;
   localparam int NB = 24;
   localparam int TW = 16;
   localparam int LW = $clog2(NL);
   localparam int BW = $clog2(NB);
   localparam int CW = 1 + LW + BW + TW;

   typedef struct {
      logic [CW-1:0] word;
      string         req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [TW-1:0] latch_cyc = '0;
   logic [TW-1:0] bit_cyc = '0;
   logic [CW-1:0] ctrl;

   exp_t q[$];
   bit   mon_en = 1'b0;
   int   n_checks = 0;
   int   n_err = 0;

   always #2 clk = ~clk;

   ledseq_frame #(
      .NUM_LEDS     (NL),
      .BITS_PER_LED (NB),
      .TIME_W       (TW)
   ) i_ledseq_frame (
      .clk_i          (clk),
      .rst_i          (rst),
      .latch_cycles_i (latch_cyc),
      .bit_cycles_i   (bit_cyc),
      .ctrl_o         (ctrl)
   );

   function automatic logic [CW-1:0] wd(int led, int b, int d);
      return {1'b1, LW'(led), BW'(b), TW'(d)};
   endfunction

   task automatic check(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input logic [CW-1:0] w, input string req);
      exp_t e;
      e.word = w;
      e.req  = req;
      q.push_back(e);
   endtask

   // Latch phase: L+1 all-zero words
   task automatic push_latch(input int L, input string first_req, input string req);
      for (int d = 0; d <= L; d++) push('0, (d == 0) ? first_req : req);
   endtask

   // One bit of one LED with period B
   task automatic push_bit(input int led, input int b, input int B, input string req);
      for (int d = 0; d <= B; d++) push(wd(led, b, d), req);
   endtask

   // Data part of a frame from (led0, b0) onward, period B
   task automatic push_data(input int led0, input int b0, input int B, input string tag);
      for (int led = led0; led < NL; led++) begin
         for (int b = (led == led0) ? b0 : 0; b < NB; b++) begin
            string r;
            if (tag != "")                 r = tag;
            else if (led == 0 && b == 0)   r = "R3";
            else if (b == 0)               r = "R6";
            else                           r = "R5";
            push_bit(led, b, B, r);
         end
      end
   endtask

   // Monitor: pops expected words and compares, between clock edges
   always begin
      @(negedge clk);
      #1;
      if (mon_en && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(ctrl, e.word, e.req);
      end
   end

   task automatic hold_reset(input int L, input int B);
      @(negedge clk);
      mon_en    = 1'b0;
      rst       = 1'b1;
      latch_cyc = TW'(L);
      bit_cyc   = TW'(B);
      q.delete();
      repeat (3) begin
         @(negedge clk);
         #1 check(ctrl, '0, "R1 in reset");
      end
   endtask

   task automatic release_and_drain();
      @(negedge clk);
      rst    = 1'b0;
      mon_en = 1'b1;
      while (q.size() != 0) @(negedge clk);
      #2;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL R7 watchdog: actual run still busy, expected completion");
      finish_run();
   end

   initial begin
      // Two frames, latch 5, bit period 3 (R1..R7)
      hold_reset(5, 3);
      push_latch(5, "R1", "R2");
      push_data(0, 0, 3, "");
      push_latch(5, "R7", "R7");
      push_data(0, 0, 3, "R7");
      push_latch(5, "R7", "R7");
      release_and_drain();

      // Minimum timing: one latch cycle, one cycle per bit (R9)
      hold_reset(0, 0);
      push_latch(0, "R1", "R9");
      push_data(0, 0, 0, "R9");
      push_latch(0, "R9", "R9");
      push_data(0, 0, 0, "R9");
      push_latch(0, "R9", "R9");
      release_and_drain();

      // Bit period cut from 7 to 2 while the count is at 5 (R8)
      hold_reset(2, 7);
      push_latch(2, "R1", "R2");
      for (int d = 0; d <= 5; d++) push(wd(0, 0, d), "R4");
      push(wd(0, 1, 0), "R8");
      for (int d = 1; d <= 2; d++) push(wd(0, 1, d), "R8");
      push_data(0, 2, 2, "R8");
      push_latch(2, "R7", "R7");
      @(negedge clk);
      rst    = 1'b0;
      mon_en = 1'b1;
      // Samples 0..2 latch, 3..8 are bit 0 counts 0..5
      repeat (8) @(negedge clk);
      bit_cyc = TW'(2);
      while (q.size() != 0) @(negedge clk);
      #2;

      finish_run();
   end

endmodule